// File: doc/BRIEF.md
# Timer with Capture and Match

A 32-bit counting block for peripheral subsystems. A prescaler divides the peripheral clock, and the main count advances once per prescaler wrap. A mode field can instead make the count follow edges seen on one of the capture inputs. In that mode the prescaler is skipped, and the remaining capture inputs keep working as normal capture channels.

There are four match channels, each with its own compare value. On a match a channel can set a sticky interrupt flag, reset the count on the following increment, or stop the timer. Each channel also drives an external output, which goes low, goes high, toggles or holds on that channel's match. There are four capture channels. Each passes its input through a two-flop synchroniser and an edge detector. On an enabled edge it snapshots the count and can raise a flag. Software reaches the block through a simple single-cycle register bus: a write strobe, an address, write data and combinational read data.

Top module: `tcm_timer`

## Requirements
- R1: With the count source set to clock (mode bits[1:0]=0, mode register at 0x01), the count (0x04) rises by one each time the prescaler (0x03) reaches the limit in 0x02 and wraps to zero. After n enabled cycles from a cleared state the count equals floor(n/(limit+1)). CTRL (0x00) bit0 enables counting; bit1 holds count and prescaler at zero.
- R2: When the reset bit of a match channel is set (bits [3c+2:3c] at 0x05 are stop, reset, irq from high to low), the count returns to 0 on the increment that follows reaching that channel's value (match c at 0x10+c). The count therefore repeats 0..value.
- R3: With the stop bit of a match channel set, CTRL bit0 clears in the same clock that the count reaches the match value, and the count holds there.
- R4: A match channel with its irq bit set raises flag bit c of the flag register (0x08) when the count reaches its value.
- R5: Each external output c takes the action in bits [2c+1:2c] of 0x07 (0 hold, 1 drive low, 2 drive high, 3 toggle) on its match event. It holds otherwise, and all outputs are low after reset.
- R6: Capture register c (0x18+c) loads the count held in the cycle when an enabled edge is detected. Detection happens two clocks after the input changes, once the input has passed through the synchroniser, so the stored value is the count after the second rising clock edge that follows the input change.
- R7: At 0x06, bits [3c] and [3c+1] enable rising and falling edge capture on channel c. An edge whose enable bit is clear leaves the capture register and flags unchanged.
- R8: Capture channel c with bit [3c+2] of 0x06 set raises flag bit 4+c on capture. Flags stay set until a 1 is written to them at 0x08. irq_o is high whenever any flag is set.
- R9: Mode bits[1:0] equal to 1, 2 or 3 count rising, falling or both edges on the capture input picked by mode bits[3:2]. The prescaler is bypassed in this mode, edges on other inputs do not count, and a one-cycle input pulse is counted.
- R10: While one input drives counter mode, the other capture channels still capture the count and set their flags.
- R11: After reset the count, CTRL, flags, irq_o and ext_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| cap_i | input | 4 | Asynchronous capture / count inputs |
| ext_o | output | 4 | Match-driven external outputs |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
The embedded properties check these rules on every cycle: the count only holds, steps by one or returns to zero; the count stays frozen in counter mode when no selected edge occurs; a stop match clears the enable; flags stay set until written with a 1; capture registers take the previous count; and outputs hold or toggle as programmed. The exact arithmetic of the prescaler and reset-on-match wrap, the three-clock capture latency, the edge-select filtering, the bypassing of the prescaler and the choice of the source input in counter mode, and the combined effect of several match channels on shared outputs all depend on sequences of register writes. Only the bench's scenarios can show these.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int unsigned AW = 5;

  localparam logic [AW-1:0] A_CTRL = 5'h00;
  localparam logic [AW-1:0] A_MODE = 5'h01;
  localparam logic [AW-1:0] A_PR   = 5'h02;
  localparam logic [AW-1:0] A_PC   = 5'h03;
  localparam logic [AW-1:0] A_TC   = 5'h04;
  localparam logic [AW-1:0] A_MCTL = 5'h05;
  localparam logic [AW-1:0] A_CCTL = 5'h06;
  localparam logic [AW-1:0] A_ECTL = 5'h07;
  localparam logic [AW-1:0] A_FLAG = 5'h08;
  localparam int unsigned   MR_BASE  = 16;
  localparam int unsigned   CAP_BASE = 24;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_TGL  = 2'd3
  } ext_act_e;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_BOTH = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/tcm_cap_sync.sv
module tcm_cap_sync #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] cap_i,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // [0],[1] synchroniser, [2] previous synced value
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], cap_i[c]};
    end
    assign rise_o[c] =  sh_q[1] & ~sh_q[2];
    assign fall_o[c] = ~sh_q[1] &  sh_q[2];

    a_r6_one_cycle_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_o[c] || fall_o[c]) |=> !(rise_o[c] && $past(rise_o[c])) && !(fall_o[c] && $past(fall_o[c])));
  end
endmodule

// File: rtl/tcm_core.sv
module tcm_core #(
  parameter int unsigned W   = 32,
  parameter int unsigned NCH = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic                    cnt_mode_i,
  input  logic                    cnt_edge_i,
  input  logic [W-1:0]            pr_i,
  input  logic [NCH-1:0][W-1:0]   mr_i,
  input  logic [NCH-1:0]          mrst_i,
  output logic [W-1:0]            tc_o,
  output logic [W-1:0]            pc_o,
  output logic [NCH-1:0]          match_o
);
  logic [W-1:0]   tc_q, pc_q, tc_nxt;
  logic [NCH-1:0] eq;
  logic           tick, rst_hit, pc_wrap;

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    assign eq[c]      = (tc_q == mr_i[c]);
    assign match_o[c] = tick & (tc_nxt == mr_i[c]);
  end

  assign pc_wrap = (pc_q >= pr_i);
  assign tick    = en_i & ~clr_i & (cnt_mode_i ? cnt_edge_i : pc_wrap);
  // reset-on-match acts on the increment after the match value was reached
  assign rst_hit = |(eq & mrst_i);
  assign tc_nxt  = rst_hit ? '0 : tc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tc_q <= '0;
      pc_q <= '0;
    end else if (clr_i) begin
      tc_q <= '0;
      pc_q <= '0;
    end else begin
      if (tick) tc_q <= tc_nxt;
      if (tick && rst_hit)           pc_q <= '0;
      else if (en_i && !cnt_mode_i)  pc_q <= pc_wrap ? '0 : pc_q + 1'b1;
    end
  end

  assign tc_o = tc_q;
  assign pc_o = pc_q;

  a_r1_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tc_q == $past(tc_q)) || (tc_q == $past(tc_q) + 1'b1) || (tc_q == '0));

  a_r9_hold_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_mode_i && !cnt_edge_i && !clr_i) |=> (tc_q == $past(tc_q)));

  a_r1_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(tc_q) && $stable(pc_q));
endmodule

// File: rtl/tcm_match_out.sv
module tcm_match_out
  import tcm_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   evt_i,
  input  logic [2*NCH-1:0] act_i,
  output logic [NCH-1:0]   ext_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_out
    ext_act_e act;
    logic     q;
    assign act = ext_act_e'(act_i[2*c +: 2]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else if (evt_i[c]) begin
        unique case (act)
          ACT_LOW:  q <= 1'b0;
          ACT_HIGH: q <= 1'b1;
          ACT_TGL:  q <= ~q;
          default:  q <= q;
        endcase
      end
    end
    assign ext_o[c] = q;

    a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[c] && act == ACT_TGL) |=> (ext_o[c] != $past(ext_o[c])));
    a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !evt_i[c] |=> $stable(ext_o[c]));
  end
endmodule

// File: rtl/tcm_timer.sv
module tcm_timer
  import tcm_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  input  logic [NCH-1:0] cap_i,
  output logic [NCH-1:0] ext_o,
  output logic           irq_o
);
  localparam int unsigned SELW  = $clog2(NCH);
  localparam int unsigned MODEW = 2 + SELW;
  localparam int unsigned FW    = 2 * NCH;

  logic                  ctrl_en_q, ctrl_clr_q;
  logic [MODEW-1:0]      mode_q;
  logic [W-1:0]          pr_q;
  logic [NCH-1:0][W-1:0] mr_q, cap_q;
  logic [3*NCH-1:0]      mctl_q, cctl_q;
  logic [FW-1:0]         ectl_q, flag_q;

  logic [W-1:0]   tc, pc;
  logic [NCH-1:0] rise, fall, match, cap_evt;
  logic [NCH-1:0] m_irq, m_rst, m_stop, c_rise, c_fall, c_irq;
  logic [SELW-1:0] sel;
  cnt_src_e       src;
  logic           cnt_mode, cnt_edge, stop_hit;
  logic [FW-1:0]  flag_set, flag_clr;

  for (genvar c = 0; c < NCH; c++) begin : g_fields
    assign m_irq[c]  = mctl_q[3*c];
    assign m_rst[c]  = mctl_q[3*c+1];
    assign m_stop[c] = mctl_q[3*c+2];
    assign c_rise[c] = cctl_q[3*c];
    assign c_fall[c] = cctl_q[3*c+1];
    assign c_irq[c]  = cctl_q[3*c+2];
  end

  tcm_cap_sync #(.NCH(NCH)) u_sync (
    .clk_i, .rst_ni, .cap_i,
    .rise_o(rise), .fall_o(fall)
  );

  assign src      = cnt_src_e'(mode_q[1:0]);
  assign sel      = mode_q[MODEW-1:2];
  assign cnt_mode = (src != SRC_CLK);
  assign cnt_edge = ((src == SRC_RISE || src == SRC_BOTH) && rise[sel]) ||
                    ((src == SRC_FALL || src == SRC_BOTH) && fall[sel]);

  tcm_core #(.W(W), .NCH(NCH)) u_core (
    .clk_i, .rst_ni,
    .en_i(ctrl_en_q), .clr_i(ctrl_clr_q),
    .cnt_mode_i(cnt_mode), .cnt_edge_i(cnt_edge),
    .pr_i(pr_q), .mr_i(mr_q), .mrst_i(m_rst),
    .tc_o(tc), .pc_o(pc), .match_o(match)
  );

  tcm_match_out #(.NCH(NCH)) u_mout (
    .clk_i, .rst_ni, .evt_i(match), .act_i(ectl_q), .ext_o
  );

  assign cap_evt  = (rise & c_rise) | (fall & c_fall);
  assign stop_hit = |(match & m_stop);
  assign flag_set = {cap_evt & c_irq, match & m_irq};
  assign flag_clr = (we_i && addr_i == A_FLAG) ? wdata_i[FW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q  <= 1'b0;
      ctrl_clr_q <= 1'b0;
      mode_q     <= '0;
      pr_q       <= '0;
      mr_q       <= '0;
      cap_q      <= '0;
      mctl_q     <= '0;
      cctl_q     <= '0;
      ectl_q     <= '0;
      flag_q     <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          A_CTRL: begin
            ctrl_en_q  <= wdata_i[0];
            ctrl_clr_q <= wdata_i[1];
          end
          A_MODE: mode_q <= wdata_i[MODEW-1:0];
          A_PR:   pr_q   <= wdata_i;
          A_MCTL: mctl_q <= wdata_i[3*NCH-1:0];
          A_CCTL: cctl_q <= wdata_i[3*NCH-1:0];
          A_ECTL: ectl_q <= wdata_i[FW-1:0];
          default: ;
        endcase
        for (int c = 0; c < NCH; c++)
          if (addr_i == AW'(MR_BASE + c)) mr_q[c] <= wdata_i;
      end
      if (stop_hit) ctrl_en_q <= 1'b0;
      for (int c = 0; c < NCH; c++)
        if (cap_evt[c]) cap_q[c] <= tc;
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  assign irq_o = |flag_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o = W'({ctrl_clr_q, ctrl_en_q});
      A_MODE: rdata_o = W'(mode_q);
      A_PR:   rdata_o = pr_q;
      A_PC:   rdata_o = pc;
      A_TC:   rdata_o = tc;
      A_MCTL: rdata_o = W'(mctl_q);
      A_CCTL: rdata_o = W'(cctl_q);
      A_ECTL: rdata_o = W'(ectl_q);
      A_FLAG: rdata_o = W'(flag_q);
      default: ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == AW'(MR_BASE + c))  rdata_o = mr_q[c];
      if (addr_i == AW'(CAP_BASE + c)) rdata_o = cap_q[c];
    end
  end

  a_r3_stop_clears_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_hit |=> !ctrl_en_q);

  for (genvar f = 0; f < FW; f++) begin : g_flag_chk
    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[f] && !flag_clr[f]) |=> flag_q[f]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cap_chk
    a_r6_capture_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_evt[c] |=> (cap_q[c] == $past(tc)));
    a_r4_match_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (match[c] && m_irq[c]) |=> flag_q[c]);
  end
endmodule

// File: tb/tb_tcm_timer.sv
`timescale 1ns/1ps
module tb_tcm_timer;
  import tcm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = '0;
  logic [3:0]  ext;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  tcm_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .ext_o(ext), .irq_o(irq)
  );

  // {prescale limit, match0, reset-on-match, enabled cycles, expected count}
  localparam logic [31:0] VEC [0:5][0:4] = '{
    '{32'd0, 32'd1000, 32'd0, 32'd10, 32'd10},
    '{32'd2, 32'd1000, 32'd0, 32'd10, 32'd3},
    '{32'd0, 32'd4,    32'd1, 32'd12, 32'd2},
    '{32'd1, 32'd3,    32'd1, 32'd19, 32'd1},
    '{32'd4, 32'd100,  32'd0, 32'd24, 32'd4},
    '{32'd0, 32'd0,    32'd1, 32'd7,  32'd0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int ch);
    cap[ch] = 1'b1;
    @(negedge clk);
    cap[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic restart();
    wr(A_CTRL, 32'd2);
    wr(A_CTRL, 32'd1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(A_TC, v);   chk(v, 0, "R11 count after reset");
    rd(A_CTRL, v); chk(v, 0, "R11 ctrl after reset");
    rd(A_FLAG, v); chk(v, 0, "R11 flags after reset");
    chk({31'd0, irq}, 0, "R11 irq_o after reset");
    chk({28'd0, ext}, 0, "R11 ext_o after reset");

    // R1 / R2 vector table
    for (int i = 0; i < 6; i++) begin
      wr(A_PR, VEC[i][0]);
      wr(5'(MR_BASE), VEC[i][1]);
      wr(A_MCTL, (VEC[i][2] != 0) ? 32'h2 : 32'h0);
      restart();
      repeat (int'(VEC[i][3]) - 1) @(negedge clk);
      wr(A_CTRL, 32'd0);
      rd(A_TC, v);
      chk(v, VEC[i][4], (VEC[i][2] != 0) ? "R2 reset-on-match wrap" : "R1 prescaled count");
    end

    // R4 match flag and R8 clear
    wr(A_PR, 0);
    wr(5'(MR_BASE), 5);
    wr(A_MCTL, 32'h1);
    wr(A_FLAG, 32'hFF);
    restart();
    repeat (9) @(negedge clk);
    wr(A_CTRL, 0);
    rd(A_FLAG, v); chk(v, 32'h1, "R4 match flag set");
    chk({31'd0, irq}, 1, "R8 irq_o with flag");
    wr(A_FLAG, 32'h1);
    rd(A_FLAG, v); chk(v, 0, "R8 write-one clears flag");
    chk({31'd0, irq}, 0, "R8 irq_o after clear");

    // R3 stop on match 1
    wr(5'(MR_BASE + 1), 3);
    wr(A_MCTL, 32'h20);
    restart();
    repeat (10) @(negedge clk);
    rd(A_TC, v);   chk(v, 3, "R3 count stops at match");
    rd(A_CTRL, v); chk(v, 0, "R3 enable cleared by stop");

    // R5 external actions: ch2 high + stop, ch3 toggle, ch1 hold
    wr(5'(MR_BASE + 1), 2);
    wr(5'(MR_BASE + 2), 2);
    wr(5'(MR_BASE + 3), 2);
    wr(A_MCTL, 32'h100);
    wr(A_ECTL, 32'hE0);
    restart();
    repeat (8) @(negedge clk);
    chk({28'd0, ext}, 32'hC, "R5 set and toggle");
    rd(A_TC, v); chk(v, 2, "R3 stop on channel 2");
    restart();
    repeat (8) @(negedge clk);
    chk({28'd0, ext}, 32'h4, "R5 second toggle, set holds");
    wr(A_ECTL, 32'h10);
    restart();
    repeat (8) @(negedge clk);
    chk({28'd0, ext}, 32'h0, "R5 drive low");

    // R6 capture while running, R8 capture flag
    wr(A_MCTL, 0);
    wr(A_ECTL, 0);
    wr(A_CCTL, 32'h28);
    wr(A_FLAG, 32'hFF);
    restart();
    cap[1] = 1'b1;
    repeat (6) @(negedge clk);
    wr(A_CTRL, 0);
    rd(5'(CAP_BASE + 1), v); chk(v, 2, "R6 captured count");
    rd(A_TC, v);             chk(v, 7, "R1 count while capturing");
    rd(A_FLAG, v);           chk(v, 32'h20, "R8 capture flag");
    wr(A_FLAG, 32'h20);
    chk({31'd0, irq}, 0, "R8 irq_o cleared");

    // R7 disabled edges ignored
    cap[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(5'(CAP_BASE + 1), v); chk(v, 2, "R7 falling edge ignored");
    rd(A_FLAG, v);           chk(v, 0, "R7 no flag on ignored edge");
    wr(A_CCTL, 32'h10);
    cap[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(5'(CAP_BASE + 1), v); chk(v, 2, "R7 rising edge ignored");
    cap[1] = 1'b0;
    repeat (5) @(negedge clk);
    rd(5'(CAP_BASE + 1), v); chk(v, 7, "R7 falling edge captured");

    // R9 counter mode on input 0, prescaler bypassed; R10 capture on input 2
    wr(A_PR, 5);
    wr(A_MODE, 32'h1);
    wr(A_CCTL, 32'h140);
    wr(A_FLAG, 32'hFF);
    restart();
    pulse(0); pulse(0); pulse(0);
    repeat (2) @(negedge clk);
    rd(A_TC, v); chk(v, 3, "R9 rising edges counted");
    pulse(1); pulse(1);
    repeat (2) @(negedge clk);
    rd(A_TC, v); chk(v, 3, "R9 unselected input ignored");
    cap[2] = 1'b1;
    repeat (6) @(negedge clk);
    rd(5'(CAP_BASE + 2), v); chk(v, 3, "R10 capture during counter mode");
    rd(A_FLAG, v);           chk(v, 32'h40, "R10 capture flag in counter mode");
    cap[2] = 1'b0;

    wr(A_MODE, 32'h3);
    restart();
    pulse(0); pulse(0);
    repeat (2) @(negedge clk);
    rd(A_TC, v); chk(v, 4, "R9 both edges counted");

    wr(A_MODE, 32'h2);
    restart();
    pulse(0); pulse(0);
    repeat (2) @(negedge clk);
    rd(A_TC, v); chk(v, 2, "R9 falling edges counted");

    summary();
    $finish;
  end
endmodule